// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a serial slave on a two-wire bus (a clock line and an open-drain data line). It gives an external host read and write access to a bank of 256 byte-wide control registers held inside the block. Both bus lines are brought into the system clock domain through synchronisers. All protocol decisions are made on edges that are detected there. The slave never drives the data line high: it only asserts an enable that pulls the line low.

The host first sends an address byte. Its upper six bits are fixed and its last bit is taken from a strap input, so two copies can share one bus. In a write, the first data byte loads a register pointer and later bytes are stored at that pointer, which then steps by one. The pointer survives stop conditions, so a later read, whether after a repeated start or in a new transaction, continues from where the last write left it. The rest of the chip reads any register through a combinational side port.

Top module: `regbank_i2c_slave`

## Requirements
- R1: A start (data falling while clock is high, both seen after synchronisation) at any point puts the slave back to expecting an address byte with its bit count at zero. A stop (data rising while clock is high) returns it to idle.
- R2: The address byte carries seven address bits MSB first and then a direction bit (1 = host reads, 0 = host writes). The slave answers to address 0x38 when `addr_sel` is 0 and 0x39 when it is 1, by pulling data low during the ninth clock.
- R3: On an address mismatch the slave keeps data released and writes nothing until the next start.
- R4: In a write, the byte after the address byte loads the 8-bit register pointer and is acknowledged.
- R5: Each further write byte is stored at the pointer and acknowledged, and the pointer then steps by one, wrapping from 0xFF to 0x00.
- R6: A read returns the register at the stored pointer MSB first, even after a stop. The pointer steps by one after every byte sent.
- R7: When the host does not acknowledge a read byte (data high on the ninth clock), the slave releases data and stays silent until the next start.
- R8: A repeated start resets the bit and byte state but keeps the register pointer.
- R9: A start or stop in the middle of a byte aborts it, and a partial write byte is never stored.
- R10: The slave only pulls data low (`sda_oe`) and starts pulling only while the synchronised clock is low. It is released after reset.
- R11: `side_rdata` shows the register addressed by `side_addr` combinationally. All registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| addr_sel | input | 1 | Strap choosing the last device address bit |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| side_addr | input | 8 | Register index for the internal read port |
| side_rdata | output | 8 | Contents of the register at `side_addr` |

## Verification
The hardest case to reach from the ports is a stop that lands part-way through a data byte, after the pointer has been set. This must leave both the register and the pointer untouched. The bench clocks four bits of a write byte by hand and issues a stop. It then reads the target register through the side port, and starts a read that must return the untouched value from the old pointer. Pointer persistence is reached by splitting a read across a stop. Wrap-around is reached by setting the pointer to 0xFF and streaming past it in both directions.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 8;
  localparam int DEPTH  = 1 << PTR_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDATA, ST_RDATA, ST_SKIP
  } slv_state_e;

  // 7-bit device address: fixed upper six bits plus strap bit
  function automatic logic [6:0] dev_addr(input logic [5:0] hi, input logic sel);
    return {hi, sel};
  endfunction

  // register pointer step, natural wrap at the top of the bank
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  // data edge with clock high on both sides of the edge
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

  // R1: at most one bus event per system cycle
  a_r1_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_evt, stop_evt}));
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [PTR_W-1:0]  side_addr,
  output logic [BYTE_W-1:0] side_rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data    = mem[rd_addr];
  assign side_rdata = mem[side_addr];
endmodule

// File: rtl/regbank_i2c_slave.sv
module regbank_i2c_slave
  import i2c_slave_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b011100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  input  logic [PTR_W-1:0]  side_addr,
  output logic [BYTE_W-1:0] side_rdata
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt));

  slv_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-2:0] tx;
  logic [PTR_W-1:0]  ptr, wr_addr;
  logic [BYTE_W-1:0] wr_data, bank_rd;
  logic              wr_en, ack_phase, slave_ack, mst_nack;
  logic              byte_done, addr_hit, active;

  assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
  assign addr_hit  = (shreg[7:1] == dev_addr(DEV_ADDR_HI, addr_sel));
  assign active    = (state != ST_IDLE) && (state != ST_SKIP);

  i2c_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(bank_rd),
    .side_addr(side_addr), .side_rdata(side_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bit_cnt <= '0; shreg <= '0; tx <= '0;
      ptr <= '0; wr_addr <= '0; wr_data <= '0; wr_en <= 1'b0;
      ack_phase <= 1'b0; slave_ack <= 1'b0; mst_nack <= 1'b0; sda_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt || stop_evt) begin
        state     <= start_evt ? ST_ADDR : ST_IDLE;
        bit_cnt   <= '0;
        ack_phase <= 1'b0;
        slave_ack <= 1'b0;
        mst_nack  <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (active && scl_rise) begin
        if (ack_phase) begin
          if (!slave_ack) mst_nack <= sda_lvl;
        end else begin
          shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end else if (active && scl_fall) begin
        if (ack_phase) begin
          ack_phase <= 1'b0;
          slave_ack <= 1'b0;
          bit_cnt   <= '0;
          if (state == ST_RDATA && !mst_nack) begin
            tx     <= bank_rd[BYTE_W-2:0];
            sda_oe <= ~bank_rd[BYTE_W-1];
          end else begin
            sda_oe <= 1'b0;
            if (state == ST_RDATA) state <= ST_SKIP;
          end
        end else if (byte_done) begin
          ack_phase <= 1'b1;
          case (state)
            ST_ADDR: begin
              if (addr_hit) begin
                sda_oe    <= 1'b1;
                slave_ack <= 1'b1;
                state     <= shreg[0] ? ST_RDATA : ST_PTR;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_PTR: begin
              ptr <= shreg; sda_oe <= 1'b1; slave_ack <= 1'b1; state <= ST_WDATA;
            end
            ST_WDATA: begin
              wr_en <= 1'b1; wr_addr <= ptr; wr_data <= shreg;
              ptr <= ptr_next(ptr); sda_oe <= 1'b1; slave_ack <= 1'b1;
            end
            ST_RDATA: begin
              sda_oe <= 1'b0; ptr <= ptr_next(ptr);
            end
            default: ;
          endcase
        end else if (state == ST_RDATA) begin
          sda_oe <= ~tx[BYTE_W-2];
          tx     <= {tx[BYTE_W-3:0], 1'b0};
        end
      end
    end
  end

  a_r1_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR) && (bit_cnt == '0));
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);
  a_r5_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == ptr_next(wr_addr)));
  a_r7_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA && ack_phase && scl_fall && mst_nack && !slave_ack)
      |=> (!sda_oe && state == ST_SKIP));
  a_r8_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (ptr == $past(ptr)));
  a_r9_whole_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(scl_fall) && $past(bit_cnt) == CNT_W'(BYTE_W)));
  a_r10_pull_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);
endmodule

// File: tb/regbank_i2c_slave_test.sv
`timescale 1ns/1ps
module regbank_i2c_slave_test;
  localparam int Q = 20;          // system cycles per quarter bus bit
  localparam int TCLK = 4;        // 250 MHz

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic [7:0] side_addr = 8'h00;
  wire  [7:0] side_rdata;
  wire        sda_oe;
  wire        sda_line = sda_m & ~sda_oe;

  always #(TCLK/2) clk = ~clk;

  regbank_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe),
    .side_addr(side_addr), .side_rdata(side_rdata));

  typedef struct { string req; int val; } item_t;
  item_t exp_q[$];
  int    obs_q[$];
  int    n_checks = 0, n_fail = 0;
  bit    done = 1'b0;

  // scoreboard monitor: pairs each observation with the oldest expectation
  always @(negedge clk) begin
    item_t e;
    int    o;
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      n_checks++;
      if (o != e.val) begin
        n_fail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", e.req, o, e.val);
      end
    end
  end

  task automatic expect_v(input string r, input int v);
    exp_q.push_back(item_t'{req: r, val: v});
  endtask

  task automatic qw; #(Q*TCLK); endtask

  task automatic bus_start;
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; qw(); scl_m = 1'b1; qw(); s = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  // sends a byte, pushes the ack bit seen on the ninth clock (0 = acked)
  task automatic wr_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    sda_m = 1'b1;
    obs_q.push_back(int'(s));
  endtask

  // receives a byte MSB first, answers with nack, pushes the byte
  task automatic rd_byte(input logic nack);
    logic s;
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, s); v = {v[6:0], s}; end
    clk_bit(nack, s);
    sda_m = 1'b1;
    obs_q.push_back(int'(v));
  endtask

  task automatic peek(input logic [7:0] a);
    side_addr = a; #(TCLK);
    obs_q.push_back(int'(side_rdata));
  endtask

  initial begin
    logic s;
    #(TCLK*5); @(negedge clk); rst_n = 1'b1; #(TCLK*4);

    // reset state
    expect_v("R10 reset release", 0); obs_q.push_back(int'(sda_oe));
    expect_v("R11 reset zero", 0); peek(8'h10);

    // write 0xA5,0x3C,0x5E from pointer 0x10 at device 0x38
    bus_start();
    expect_v("R2 addr ack sel0", 0); wr_byte(8'h70);
    expect_v("R4 pointer ack", 0);   wr_byte(8'h10);
    expect_v("R5 data ack", 0);      wr_byte(8'hA5);
    expect_v("R5 data ack", 0);      wr_byte(8'h3C);
    expect_v("R5 data ack", 0);      wr_byte(8'h5E);
    bus_stop();
    expect_v("R5 stored 0x10", 'hA5); peek(8'h10);
    expect_v("R5 stored 0x11", 'h3C); peek(8'h11);
    expect_v("R11 side 0x12", 'h5E);  peek(8'h12);

    // set pointer, repeated start, read two bytes
    bus_start();
    expect_v("R2 addr ack", 0); wr_byte(8'h70);
    expect_v("R4 pointer ack", 0); wr_byte(8'h10);
    bus_start();
    expect_v("R8 R1 addr after repeated start", 0); wr_byte(8'h71);
    expect_v("R6 read first", 'hA5); rd_byte(1'b0);
    expect_v("R6 read second", 'h3C); rd_byte(1'b1);
    expect_v("R7 released after nack", 0); obs_q.push_back(int'(sda_oe));
    expect_v("R7 silent after nack", 'hFF); rd_byte(1'b1);
    bus_stop();

    // pointer persists across stop
    bus_start();
    expect_v("R2 addr ack read", 0); wr_byte(8'h71);
    expect_v("R6 continue after stop", 'h5E); rd_byte(1'b1);
    bus_stop();

    // mismatch: 0x39 while strap selects 0x38
    bus_start();
    expect_v("R3 no addr ack", 1); wr_byte(8'h72);
    expect_v("R3 ignored byte", 1); wr_byte(8'h00);
    expect_v("R3 ignored byte", 1); wr_byte(8'h99);
    bus_stop();
    expect_v("R3 no write", 0); peek(8'h00);

    // strap selects 0x39, write across the top of the bank
    addr_sel = 1'b1; #(TCLK*4);
    bus_start();
    expect_v("R2 addr ack sel1", 0); wr_byte(8'h72);
    expect_v("R4 pointer ack", 0); wr_byte(8'hFF);
    expect_v("R5 data ack", 0); wr_byte(8'h11);
    expect_v("R5 data ack", 0); wr_byte(8'h22);
    bus_stop();
    expect_v("R5 stored 0xFF", 'h11); peek(8'hFF);
    expect_v("R5 wrap to 0x00", 'h22); peek(8'h00);
    bus_start();
    expect_v("R2 old address refused", 1); wr_byte(8'h70);
    bus_stop();

    // read across the wrap
    bus_start();
    expect_v("R2 addr ack", 0); wr_byte(8'h72);
    expect_v("R4 pointer ack", 0); wr_byte(8'hFF);
    bus_start();
    expect_v("R8 addr ack", 0); wr_byte(8'h73);
    expect_v("R6 read 0xFF", 'h11); rd_byte(1'b0);
    expect_v("R6 read wrapped", 'h22); rd_byte(1'b1);
    bus_stop();

    // stop in the middle of a write byte
    bus_start();
    expect_v("R2 addr ack", 0); wr_byte(8'h72);
    expect_v("R4 pointer ack", 0); wr_byte(8'h40);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    bus_stop();
    expect_v("R9 partial not stored", 0); peek(8'h40);
    expect_v("R9 R10 released after abort", 0); obs_q.push_back(int'(sda_oe));
    bus_start();
    expect_v("R1 addr after abort", 0); wr_byte(8'h73);
    expect_v("R9 pointer unchanged", 'h00); rd_byte(1'b1);
    bus_stop();

    #(TCLK*10);
    while (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      n_checks++; n_fail++;
      $display("FAIL %s: actual none expected 0x%0h", e.req, e.val);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule